// File: doc/BRIEF.md
# Round-Robin Slave-Port Arbiter

This block decides which of up to six bus masters owns one slave port of a multi-master system interconnect. Each master presents a request line and a burst-continue line toward this slave; address decoding that selects the slave happens in front of the arbiter, per master. The arbiter returns a registered one-hot grant together with a strobe that marks the first cycle of every new grant value. The data path and the crossbar around it are outside this block.

Competing requests are served in rotating order. The search starts with the master that follows the one granted most recently. A grant normally stays with its owner until a transfer boundary. A programmable slot limit caps how many transfer cycles one grant may use inside a single burst. When the limit is reached, arbitration runs again and the slot counter reloads. While no master requests, one of three idle policies decides the grant: nobody, the previous owner, or a configured default master. A master that already holds the grant through an idle policy can transfer in the very cycle its request rises.

Timing model: `gnt_o` in cycle t applies to the requests seen in cycle t. The arbitration result computed from cycle t's inputs appears on `gnt_o` in cycle t+1. A transfer cycle is a cycle in which the granted master has its request high. A transfer boundary is any cycle in which the owner does not have both request and burst-continue high.

Top module: `rrarb_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `gnt_o` is all zero and `gnt_chg_o` is low.
- R2: `gnt_o` never has more than one bit set. If any request is high in cycle t, then the grant in cycle t+1 belongs to a master whose request was high in cycle t.
- R3: When arbitration runs with requests pending, the winner is the first requesting master found by searching upward from the index after the last granted master and wrapping from N-1 to 0. After reset, the search starts at master 0.
- R4: When the owner has request and burst-continue high and the slot limit has not expired, the grant is unchanged in the next cycle.
- R5: With `slot_lim_i` = L > 0, a grant expires in the L-th consecutive transfer cycle of a burst, and arbitration runs again. Every arbitration reloads the count, so a lone bursting master is granted again and starts a fresh slot.
- R6: With `slot_lim_i` = 0, a burst is never broken, however long it runs.
- R7: With idle mode 0 (no default), a cycle with no request leads to an all-zero grant in the next cycle.
- R8: With idle mode 1 (keep last), a cycle with no request leaves the grant unchanged in the next cycle.
- R9: With idle mode 2 (fixed default), a cycle with no request leads to grant bit `dflt_mst_i` in the next cycle. If `dflt_mst_i` is N or larger, the grant is all zero.
- R10: A master that holds the grant through an idle policy sees its grant bit already high in the same cycle its request rises, with no grant change.
- R11: `gnt_chg_o` is high in exactly those cycles in which `gnt_o` differs from its value in the previous cycle.
- R12: Idle mode code 3 behaves the same as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Per-master request toward this slave |
| burst_i | input | N_MST | Per-master burst-continue; high means the current transfer is not the last of its burst |
| idle_mode_i | input | 2 | Idle policy: 0 none, 1 keep last, 2 fixed default, 3 none |
| dflt_mst_i | input | clog2(N_MST) | Master index granted in fixed-default idle mode |
| slot_lim_i | input | SLOT_W | Transfer cycles allowed per grant within a burst; 0 means no limit |
| gnt_o | output | N_MST | Registered one-hot grant, or all zero |
| gnt_chg_o | output | 1 | High in the first cycle of a new grant value |

## Verification
A corrupted last-owner index shows up at the next contended arbitration, one cycle later, as a grant to a master that is not the next one in rotation. A slot counter that is stuck or off by one moves the point where a burst is broken. With small limits, this is visible within a few cycles as an early or late grant change. Wrong idle-policy state appears in the first cycle after the requests fall, and a missing or extra change strobe is visible in the same cycle as the grant edge. The bench runs a cycle-accurate reference model under sweeps of every idle mode, small slot limits and all default indices, and compares the outputs on every cycle.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;
  typedef enum logic [1:0] {
    IDLE_NONE  = 2'd0,
    IDLE_LAST  = 2'd1,
    IDLE_FIXED = 2'd2,
    IDLE_RSVD  = 2'd3
  } idle_mode_e;
endpackage

// File: rtl/rrarb_pick.sv
// Rotating-priority search: first requester after last_i, wrapping.
module rrarb_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          hit_o
);
  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] base, input int k);
    logic [IW:0] s;
    s = {1'b0, base} + (IW+1)'(k);
    if (s >= (IW+1)'(N)) s = s - (IW+1)'(N);
    return s[IW-1:0];
  endfunction

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      if (!hit_o && req_i[wrap_add(last_i, k)]) begin
        hit_o = 1'b1;
        idx_o = wrap_add(last_i, k);
      end
    end
    gnt_o = '0;
    if (hit_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/rrarb_idle.sv
// Grant chosen when no master requests.
module rrarb_idle
  import rrarb_pkg::*;
#(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  idle_mode_e    mode_i,
  input  logic [IW-1:0] dflt_i,
  input  logic [N-1:0]  held_i,
  output logic [N-1:0]  gnt_o
);
  logic [N-1:0] fix_oh;

  for (genvar m = 0; m < N; m++) begin : g_fix
    assign fix_oh[m] = (dflt_i == IW'(m));
  end

  always_comb begin
    unique case (mode_i)
      IDLE_LAST:  gnt_o = held_i;
      IDLE_FIXED: gnt_o = fix_oh;
      default:    gnt_o = '0;
    endcase
  end
endmodule

// File: rtl/rrarb_slot.sv
// Transfer-cycle counter for burst breaking; lim 0 disables.
module rrarb_slot #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [SW-1:0] lim_i,
  output logic          expire_o
);
  localparam logic [SW-1:0] CNT_MAX = '1;
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (lim_i != '0) && (cnt_q >= lim_i - 1'b1);
endmodule

// File: rtl/rrarb_slave.sv
module rrarb_slave
  import rrarb_pkg::*;
#(
  parameter int N_MST  = 6,
  parameter int SLOT_W = 8,
  localparam int IW    = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MST-1:0]  req_i,
  input  logic [N_MST-1:0]  burst_i,
  input  logic [1:0]        idle_mode_i,
  input  logic [IW-1:0]     dflt_mst_i,
  input  logic [SLOT_W-1:0] slot_lim_i,
  output logic [N_MST-1:0]  gnt_o,
  output logic              gnt_chg_o
);
  localparam logic [IW-1:0] LAST_RST = IW'(N_MST - 1);

  logic [N_MST-1:0] gnt_q, gnt_d, pick_gnt, idle_gnt;
  logic [IW-1:0]    last_q, pick_idx;
  logic             pick_hit, chg_q;
  logic             own_req, own_burst, slot_exp, rearb;

  function automatic logic [IW-1:0] oh2idx(input logic [N_MST-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int m = 0; m < N_MST; m++) if (v[m]) r = IW'(m);
    return r;
  endfunction

  assign own_req   = |(gnt_q & req_i);
  assign own_burst = |(gnt_q & req_i & burst_i);
  // re-run arbitration at a boundary, when nobody owns, or on slot expiry
  assign rearb     = (gnt_q == '0) || !own_burst || (own_req && slot_exp);

  rrarb_pick #(.N(N_MST), .IW(IW)) u_pick (
    .req_i  (req_i),
    .last_i (last_q),
    .gnt_o  (pick_gnt),
    .idx_o  (pick_idx),
    .hit_o  (pick_hit)
  );

  rrarb_idle #(.N(N_MST), .IW(IW)) u_idle (
    .mode_i (idle_mode_e'(idle_mode_i)),
    .dflt_i (dflt_mst_i),
    .held_i (gnt_q),
    .gnt_o  (idle_gnt)
  );

  rrarb_slot #(.SW(SLOT_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rearb),
    .inc_i    (!rearb),
    .lim_i    (slot_lim_i),
    .expire_o (slot_exp)
  );

  always_comb begin
    if (!rearb)        gnt_d = gnt_q;
    else if (pick_hit) gnt_d = pick_gnt;
    else               gnt_d = idle_gnt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      chg_q  <= 1'b0;
      last_q <= LAST_RST;
    end else begin
      gnt_q <= gnt_d;
      chg_q <= (gnt_d != gnt_q);
      if (pick_hit && rearb) last_q <= pick_idx;
      else if (gnt_d != '0)  last_q <= oh2idx(gnt_d);
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_chg_o = chg_q;
endmodule

// File: rtl/rrarb_slave_chk.sv
module rrarb_slave_chk #(
  parameter int N_MST  = 6,
  parameter int SLOT_W = 8,
  localparam int IW    = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_MST-1:0]  req_i,
  input logic [N_MST-1:0]  burst_i,
  input logic [1:0]        idle_mode_i,
  input logic [IW-1:0]     dflt_mst_i,
  input logic [SLOT_W-1:0] slot_lim_i,
  input logic [N_MST-1:0]  gnt_o,
  input logic              gnt_chg_o
);
  logic [N_MST-1:0] fix_oh;
  always_comb begin
    fix_oh = '0;
    for (int m = 0; m < N_MST; m++) if (dflt_mst_i == IW'(m)) fix_oh[m] = 1'b1;
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_to_requester_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |=> ((gnt_o & $past(req_i)) != '0));

  p_burst_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((gnt_o & req_i & burst_i) != '0) && slot_lim_i == '0) |=> $stable(gnt_o));

  p_idle_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && (idle_mode_i == 2'd0 || idle_mode_i == 2'd3)) |=> (gnt_o == '0));

  p_idle_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && idle_mode_i == 2'd1) |=> $stable(gnt_o));

  p_idle_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && idle_mode_i == 2'd2) |=> (gnt_o == $past(fix_oh)));

  p_chg_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (gnt_chg_o == (gnt_o != $past(gnt_o))));
endmodule

bind rrarb_slave rrarb_slave_chk #(.N_MST(N_MST), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/rrarb_slave_tb_top.sv
`timescale 1ns/1ps
module rrarb_slave_tb_top;
  localparam int N  = 6;
  localparam int SW = 8;
  localparam int IW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0, burst_i = '0;
  logic [1:0]    idle_mode_i = 2'd0;
  logic [IW-1:0] dflt_mst_i = '0;
  logic [SW-1:0] slot_lim_i = '0;
  logic [N-1:0]  gnt_o;
  logic          gnt_chg_o;

  int vectors = 0, miscmp = 0, cycles = 0;

  // reference model state
  logic [N-1:0] m_gnt;
  logic         m_chg;
  int           m_last, m_cnt;

  always #4 clk_i = ~clk_i;

  rrarb_slave #(.N_MST(N), .SLOT_W(SW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 200000) begin
      chk(1'b0, "watchdog", cycles, 200000);
      finish_run();
    end
  end

  function automatic logic [N-1:0] model_next(output bit rearb);
    logic [N-1:0] nx;
    bit oreq, oburst, exp;
    int lim;
    lim    = int'(slot_lim_i);
    oreq   = (m_gnt & req_i) != '0;
    oburst = (m_gnt & req_i & burst_i) != '0;
    exp    = (lim != 0) && oreq && (m_cnt >= lim - 1);
    rearb  = (m_gnt == '0) || !oburst || exp;
    nx = m_gnt;
    if (rearb) begin
      nx = '0;
      if (req_i != '0) begin
        for (int k = 1; k <= N; k++) begin
          int p;
          p = (m_last + k) % N;
          if (nx == '0 && req_i[p]) nx[p] = 1'b1;
        end
      end else begin
        case (idle_mode_i)
          2'd1: nx = m_gnt;
          2'd2: if (int'(dflt_mst_i) < N) nx[dflt_mst_i] = 1'b1;
          default: nx = '0;
        endcase
      end
    end
    return nx;
  endfunction

  // inputs already applied at negedge; advance one clock, then compare
  task automatic cyc(input logic [N-1:0] rq, input logic [N-1:0] bu, input string tag);
    logic [N-1:0] nx;
    bit rearb;
    req_i = rq;
    burst_i = bu;
    nx = model_next(rearb);
    @(posedge clk_i);
    m_chg = (nx != m_gnt);
    if (rearb) m_cnt = 0;
    else if (m_cnt < 255) m_cnt++;
    m_gnt = nx;
    for (int m = 0; m < N; m++) if (nx[m]) m_last = m;
    @(negedge clk_i);
    chk(gnt_o == m_gnt, tag, int'(gnt_o), int'(m_gnt));
    chk(gnt_chg_o == m_chg, "R11 strobe", int'(gnt_chg_o), int'(m_chg));
  endtask

  task automatic cfg(input logic [1:0] md, input int lim, input int df);
    idle_mode_i = md;
    slot_lim_i  = SW'(lim);
    dflt_mst_i  = IW'(df);
  endtask

  initial begin
    m_gnt = '0; m_chg = 1'b0; m_last = N - 1; m_cnt = 0;
    repeat (3) @(negedge clk_i);
    chk(gnt_o == '0, "R1 grant in reset", int'(gnt_o), 0);
    rst_ni = 1'b1;
    chk(gnt_o == '0 && gnt_chg_o == 1'b0, "R1 after release", int'({gnt_chg_o, gnt_o}), 0);

    // R7 idle none
    cfg(2'd0, 0, 0);
    repeat (2) cyc('0, '0, "R7 idle none");
    // R3 rotation among 0,2,5 single transfers
    repeat (8) cyc(6'b100101, '0, "R3 rotation");
    repeat (6) cyc(6'b111111, '0, "R3 rotation all");
    // R4 hold while bursting, others waiting
    cyc(6'b000010, 6'b000010, "R4 start burst");
    repeat (6) cyc(6'b011010, 6'b000010, "R4 burst hold");
    cyc(6'b011010, 6'b000000, "R4 burst end");
    cyc(6'b011000, 6'b000000, "R4 next owner");
    // R5 slot limit 3 with contender
    cfg(2'd0, 3, 0);
    repeat (12) cyc(6'b010010, 6'b010010, "R5 slot break");
    // R5 lone master re-granted
    repeat (8) cyc(6'b000100, 6'b000100, "R5 lone regrant");
    cfg(2'd0, 1, 0);
    repeat (6) cyc(6'b100001, 6'b100001, "R5 limit one");
    // R6 no limit
    cfg(2'd0, 0, 0);
    repeat (40) cyc(6'b010010, 6'b010010, "R6 unbroken");
    // R8 keep last
    cfg(2'd1, 0, 0);
    cyc(6'b001000, '0, "R8 grant");
    repeat (4) cyc('0, '0, "R8 hold idle");
    // R10 zero latency under keep-last
    @(negedge clk_i);
    req_i = 6'b001000; burst_i = 6'b001000;
    #1 chk(gnt_o[3] == 1'b1, "R10 same cycle last", int'(gnt_o), 8);
    cyc(6'b001000, 6'b001000, "R10 hold");
    // R9 fixed default
    cfg(2'd2, 0, 4);
    repeat (3) cyc('0, '0, "R9 fixed idle");
    @(negedge clk_i);
    req_i = 6'b010000; burst_i = 6'b010000;
    #1 chk(gnt_o == 6'b010000, "R10 same cycle fixed", int'(gnt_o), 16);
    cyc(6'b010000, 6'b010000, "R10 no change");
    cyc(6'b010000, 6'b000000, "R10 end");
    cfg(2'd2, 0, 7);
    repeat (2) cyc('0, '0, "R9 out of range");
    // R12 reserved code
    cfg(2'd3, 0, 2);
    cyc(6'b000100, '0, "R12 grant");
    repeat (2) cyc('0, '0, "R12 idle as none");

    // sweep over modes, small limits, all default indices
    for (int md = 0; md < 4; md++)
      for (int li = 0; li < 4; li++)
        for (int df = 0; df < 8; df++) begin
          cfg(2'(md), li, df);
          for (int t = 0; t < 30; t++) begin
            logic [N-1:0] rq, bu;
            rq = N'($urandom) & N'($urandom);
            if ((t % 7) > 4) rq = '0;
            bu = N'($urandom) | N'($urandom);
            cyc(rq, bu, "R2 sweep");
          end
        end
    finish_run();
  end
endmodule